// File: doc/BRIEF.md
# Slave-Port Bus Arbiter with Qualified Re-Arbitration

This block decides which of several bus masters owns one slave port of a multi-master interconnect. Every slave port gets its own instance, so neighbouring slaves can run different policies side by side. Each master raises a request line. The arbiter holds a registered one-hot grant that names the current owner.

A grant may change only at a point where changing it cannot break a transfer. A separate burst-tracking block reports these points on four qualifier inputs:
- the slave is idle, or its owner is not accessing it;
- a single, non-burst transfer is in progress;
- the current beat is the last one of a burst;
- the slot-cycle limit has expired.

On any edge where at least one qualifier is high, the arbiter picks a new owner. A mode input selects the policy: rotating round-robin or fixed priority with a 2-bit level per master. When nobody requests, ownership parks on a configurable default master.

Top module: `slv_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, before any qualifier is seen, `gnt` is all zeros.
- R2: `gnt` is registered and always has at most one bit set.
- R3: On a clock edge where all four qualifiers are low, `gnt` keeps its value, whatever the requests and the mode. This is how a burst is kept whole.
- R4: Each qualifier on its own (`bus_idle`, `single_xfer`, `burst_end`, `slot_hit`) allows a new decision. When any master requests at such an edge, the new grant goes to a master that was requesting.
- R5: With `arb_mode` = 0 (round-robin, the reset policy), the first decision after reset that sees several requests grants the lowest-numbered requester.
- R6: In round-robin mode the search for the next owner starts at the master just after the last round-robin winner, wrapping from the highest index to 0. Decisions made in fixed mode, and parking, leave this search position unchanged.
- R7: With `arb_mode` = 1 (fixed priority), the requester with the largest level wins. The level of master i is `prio_lvl[2*i+1:2*i]`.
- R8: In fixed-priority mode, a tie on the largest level goes to the lowest-numbered requester.
- R9: At a qualified edge with no requests, `gnt` becomes the one-hot code of `dflt_mst`, which must be below the master count.
- R10: `arb_mode` may change between decisions. The next qualified edge uses the new policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_MST | Request line per master |
| arb_mode | input | 1 | 0 = round-robin, 1 = fixed priority |
| prio_lvl | input | NUM_MST*PRIO_W | Fixed-priority level per master, packed by index |
| dflt_mst | input | $clog2(NUM_MST) | Index of the parking master |
| bus_idle | input | 1 | Qualifier: slave idle or not accessed by its owner |
| single_xfer | input | 1 | Qualifier: single transfer in progress |
| burst_end | input | 1 | Qualifier: last beat of a burst |
| slot_hit | input | 1 | Qualifier: slot-cycle limit reached |
| gnt | output | NUM_MST | One-hot registered grant |

## Verification
The bench holds a burst open with all qualifiers low while other masters request, then releases it through `slot_hit`. A design that re-arbitrates on requests alone would hand the slave away in mid-burst. Round-robin is driven through a full wrap with every master requesting, which exposes an off-by-one rotation pointer or a pointer that fails to wrap. It also checks that parking and fixed-mode decisions do not disturb the rotation. Fixed-priority tests include ties on the top level, which catch a picker that prefers the highest index. Parking with no requests catches a grant that is dropped to zero or left on the old owner.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;
   typedef enum logic {
      ARB_ROUND = 1'b0,
      ARB_FIXED = 1'b1
   } arb_mode_e;
endpackage

// File: rtl/slv_arb_qual.sv
// Collapses the burst tracker's qualifier lines into one decision strobe.
module slv_arb_qual #(
   parameter int NUM_Q = 4
) (
   input  logic [NUM_Q-1:0] qual,
   output logic             arb_pt
);
   assign arb_pt = |qual;
endmodule

// File: rtl/slv_arb_rr_pick.sv
// Rotating search: first requester at or after the pointer.
module slv_arb_rr_pick #(
   parameter int NUM_MST = 4,
   parameter int IDX_W   = 2
) (
   input  logic [NUM_MST-1:0] req,
   input  logic [IDX_W-1:0]   ptr,
   output logic               any,
   output logic [IDX_W-1:0]   win
);
   always_comb begin
      int idx;
      any = 1'b0;
      win = '0;
      // Walk offsets from far to near so the nearest requester is kept last.
      for (int k = NUM_MST - 1; k >= 0; k--) begin
         idx = (int'(ptr) + k) % NUM_MST;
         if (req[idx]) begin
            any = 1'b1;
            win = IDX_W'(idx);
         end
      end
   end
endmodule

// File: rtl/slv_arb_prio_pick.sv
// Fixed-level search: largest level wins, lowest index breaks ties.
module slv_arb_prio_pick #(
   parameter int NUM_MST = 4,
   parameter int PRIO_W  = 2,
   parameter int IDX_W   = 2
) (
   input  logic [NUM_MST-1:0]        req,
   input  logic [NUM_MST*PRIO_W-1:0] prio_lvl,
   output logic [IDX_W-1:0]          win
);
   always_comb begin
      logic              found;
      logic [PRIO_W-1:0] best;
      found = 1'b0;
      best  = '0;
      win   = '0;
      // Descending scan with >= so an equal level at a lower index replaces.
      for (int i = NUM_MST - 1; i >= 0; i--) begin
         if (req[i] && (!found || prio_lvl[i*PRIO_W +: PRIO_W] >= best)) begin
            found = 1'b1;
            best  = prio_lvl[i*PRIO_W +: PRIO_W];
            win   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/slv_arbiter.sv
module slv_arbiter
   import slv_arb_pkg::*;
#(
   parameter int  NUM_MST  = 4,
   parameter int  PRIO_W   = 2,
   parameter bit  USE_FIXED = 1'b1,
   localparam int IDX_W    = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_MST-1:0]        req,
   input  logic                      arb_mode,
   input  logic [NUM_MST*PRIO_W-1:0] prio_lvl,
   input  logic [IDX_W-1:0]          dflt_mst,
   input  logic                      bus_idle,
   input  logic                      single_xfer,
   input  logic                      burst_end,
   input  logic                      slot_hit,
   output logic [NUM_MST-1:0]        gnt
);
   localparam int NUM_Q = 4;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_MST - 1);

   if (NUM_MST < 2) begin : g_bad_mst
      $error("slv_arbiter: NUM_MST must be at least 2");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("slv_arbiter: PRIO_W must be at least 1");
   end

   arb_mode_e             mode;
   logic                  arb_pt;
   logic                  rr_any;
   logic [IDX_W-1:0]      rr_win;
   logic [IDX_W-1:0]      fx_win;
   logic [IDX_W-1:0]      pick;
   logic [IDX_W-1:0]      rr_ptr_q;
   logic [NUM_MST-1:0]    gnt_q;
   logic [NUM_MST-1:0]    gnt_nxt;

   assign mode = arb_mode_e'(arb_mode);

   slv_arb_qual #(.NUM_Q(NUM_Q)) u_qual (
      .qual   ({slot_hit, burst_end, single_xfer, bus_idle}),
      .arb_pt (arb_pt)
   );

   slv_arb_rr_pick #(.NUM_MST(NUM_MST), .IDX_W(IDX_W)) u_rr (
      .req (req),
      .ptr (rr_ptr_q),
      .any (rr_any),
      .win (rr_win)
   );

   // A round-robin-only build drops the level comparator entirely.
   if (USE_FIXED) begin : g_fixed
      slv_arb_prio_pick #(.NUM_MST(NUM_MST), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_fx (
         .req      (req),
         .prio_lvl (prio_lvl),
         .win      (fx_win)
      );
      assign pick = (mode == ARB_FIXED) ? fx_win : rr_win;
   end else begin : g_rr_only
      logic unused_fx;
      assign unused_fx = ^{prio_lvl, mode};
      assign fx_win    = '0;
      assign pick      = rr_win;
   end

   always_comb begin
      gnt_nxt = '0;
      if (rr_any) gnt_nxt[pick]     = 1'b1;
      else        gnt_nxt[dflt_mst] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_q    <= '0;
         rr_ptr_q <= '0;
      end else if (arb_pt) begin
         gnt_q <= gnt_nxt;
         if (rr_any && (!USE_FIXED || mode == ARB_ROUND))
            rr_ptr_q <= (rr_win == LAST_IDX) ? '0 : rr_win + 1'b1;
      end
   end

   assign gnt = gnt_q;
endmodule

// File: rtl/slv_arbiter_chk.sv
module slv_arbiter_chk #(
   parameter int NUM_MST = 4,
   parameter int IDX_W   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_MST-1:0] req,
   input logic [IDX_W-1:0]   dflt_mst,
   input logic               bus_idle,
   input logic               single_xfer,
   input logic               burst_end,
   input logic               slot_hit,
   input logic [NUM_MST-1:0] gnt
);
   logic qual_any;
   assign qual_any = bus_idle | single_xfer | burst_end | slot_hit;

   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   assert_burst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !qual_any |=> $stable(gnt));

   assert_to_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_any && (|req)) |=> ((gnt & $past(req)) != '0));

   assert_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_any && !(|req)) |=> (gnt == (NUM_MST'(1) << $past(dflt_mst))));
endmodule

bind slv_arbiter slv_arbiter_chk #(.NUM_MST(NUM_MST), .IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req         (req),
   .dflt_mst    (dflt_mst),
   .bus_idle    (bus_idle),
   .single_xfer (single_xfer),
   .burst_end   (burst_end),
   .slot_hit    (slot_hit),
   .gnt         (gnt)
);

// File: tb/tb_slv_arbiter.sv
`timescale 1ns/1ps
module tb_slv_arbiter;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic         arb_mode = 1'b0;
   logic [2*N-1:0] prio_lvl = '0;
   logic [1:0]   dflt_mst = '0;
   logic         bus_idle = 1'b0, single_xfer = 1'b0, burst_end = 1'b0, slot_hit = 1'b0;
   logic [N-1:0] gnt;

   always #4 clk = ~clk;  // 125 MHz

   slv_arbiter #(.NUM_MST(N)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .arb_mode(arb_mode),
      .prio_lvl(prio_lvl), .dflt_mst(dflt_mst), .bus_idle(bus_idle),
      .single_xfer(single_xfer), .burst_end(burst_end), .slot_hit(slot_hit),
      .gnt(gnt)
   );

   typedef struct {
      logic [N-1:0] exp;
      string        tag;
   } item_t;

   item_t        sb_q[$];
   int           total = 0;
   int           bad = 0;
   bit           done = 1'b0;
   int           m_ptr = 0;
   logic [N-1:0] m_gnt = '0;

   // Monitor: one expected item per clock edge, sampled after the edge settles.
   always @(posedge clk) begin
      #2;
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         total++;
         if (gnt !== it.exp) begin
            bad++;
            $display("FAIL %s: gnt=%b expected=%b", it.tag, gnt, it.exp);
         end
      end
   end

   // Driver: q = {slot_hit, burst_end, single_xfer, bus_idle}.
   task automatic step(input logic [N-1:0] r, input bit fx, input logic [2*N-1:0] p,
                       input logic [1:0] d, input logic [3:0] q, input string tag);
      item_t it;
      int w;
      @(negedge clk);
      req = r; arb_mode = fx; prio_lvl = p; dflt_mst = d;
      {slot_hit, burst_end, single_xfer, bus_idle} = q;
      if (q != 4'b0000) begin
         if (r != '0) begin
            w = -1;
            if (fx) begin
               int best = -1;
               for (int i = 0; i < N; i++)
                  if (r[i] && int'(p[2*i +: 2]) > best) begin best = int'(p[2*i +: 2]); w = i; end
            end else begin
               for (int k = N - 1; k >= 0; k--)
                  if (r[(m_ptr + k) % N]) w = (m_ptr + k) % N;
               m_ptr = (w + 1) % N;
            end
            m_gnt = '0; m_gnt[w] = 1'b1;
         end else begin
            m_gnt = '0; m_gnt[d] = 1'b1;
         end
      end
      it.exp = m_gnt; it.tag = tag;
      sb_q.push_back(it);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run hung, queue=%0d expected=0", sb_q.size());
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      total++;
      if (gnt !== '0) begin bad++; $display("FAIL R1: gnt=%b expected=0000 in reset", gnt); end
      rst_n = 1'b1;
      @(negedge clk);
      total++;
      if (gnt !== '0) begin bad++; $display("FAIL R1: gnt=%b expected=0000 after reset", gnt); end

      // R5/R6: round-robin from reset, full wrap with everyone requesting.
      step(4'b1111, 0, 8'h00, 2'd0, 4'b0001, "R5");
      step(4'b1111, 0, 8'h00, 2'd0, 4'b0010, "R6");
      step(4'b1111, 0, 8'h00, 2'd0, 4'b0100, "R6");
      step(4'b1111, 0, 8'h00, 2'd0, 4'b0001, "R6");
      step(4'b1111, 0, 8'h00, 2'd0, 4'b0010, "R6");   // wraps to master 0
      // R3: burst in flight, others request, no qualifier.
      step(4'b1110, 0, 8'h00, 2'd0, 4'b0000, "R3");
      step(4'b0110, 1, 8'hFF, 2'd3, 4'b0000, "R3");
      step(4'b0000, 0, 8'h00, 2'd2, 4'b0000, "R3");
      // R4: slot limit breaks the burst; search resumes after master 0.
      step(4'b1110, 0, 8'h00, 2'd0, 4'b1000, "R4");
      step(4'b1001, 0, 8'h00, 2'd0, 4'b0100, "R4");   // burst_end, from ptr 2 -> master 3
      // R9: parking does not move the rotation.
      step(4'b0000, 0, 8'h00, 2'd2, 4'b0001, "R9");
      step(4'b0000, 0, 8'h00, 2'd1, 4'b0010, "R9");
      step(4'b0011, 0, 8'h00, 2'd1, 4'b0001, "R6");   // ptr 0 -> master 0
      // R7/R8/R10: fixed priority; levels m3..m0 = 3,2,3,1.
      step(4'b1111, 1, 8'b11_10_11_01, 2'd0, 4'b0001, "R8");
      step(4'b0101, 1, 8'b11_10_11_01, 2'd0, 4'b0010, "R7");
      step(4'b1100, 1, 8'b00_00_00_00, 2'd0, 4'b0100, "R8");
      step(4'b1011, 1, 8'b11_00_01_10, 2'd0, 4'b1000, "R7");
      // R10: back to round-robin; fixed decisions left ptr at 1.
      step(4'b1101, 0, 8'hFF, 2'd0, 4'b0001, "R10");
      step(4'b1101, 0, 8'hFF, 2'd0, 4'b0001, "R10");
      step(4'b0000, 0, 8'h00, 2'd0, 4'b0000, "R3");

      while (sb_q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule